// File: doc/BRIEF.md
# Bridge Interrupt Status Aggregator

This block gathers the interrupt sources of a PCIe root-port bridge into one place that software can inspect. It holds two status registers. The local status word latches six error events (post, fetch and discard failures, seen on the AXI side and on the PCIe side), the four legacy INTA to INTD assertions, and a summary flag for message-signalled interrupts. A separate register holds 32 MSI vectors. An inbound MSI memory write whose address equals a programmable target address sets the vector bit that its data value selects.

Software reaches a mask register, the two status registers and the MSI target address through a small register bus. The bus has a word index, a write strobe and a read strobe, and read data returns one cycle after the read strobe. Both status registers are write-one-to-clear. A single level interrupt line goes to the CPU. It stays high while any status bit whose mask bit is set remains set.

Top module: `bridge_irq_agg`

## Requirements
- R1: After reset the mask register, the local status word, the MSI vector register and `irq_o` are all zero, and the MSI target register holds the parameter `MSI_TGT_RST` (default 0x2000_0040).
- R2: A high on `err_evt_i[k]` latches a status bit. For k = 0, 1 and 2 (AXI post, fetch, discard) the bit is 16, 17 and 18. For k = 3, 4 and 5 (PCIe post, fetch, discard) the bit is 20, 21 and 22. The bit stays set after the input falls.
- R3: A high on `intx_evt_i[j]` (j = 0 to 3 for INTA to INTD) latches status bit 24 + j.
- R4: An MSI write sets MSI vector bit N on the next clock edge when three conditions hold: `msi_wr_i` is high, `msi_addr_i` equals the target register, and `msi_data_i` = N is below 32.
- R5: An MSI write is ignored when its data is 32 or more or when its address differs from the target. Reprogramming the target moves the address that is accepted.
- R6: Local status bit 28 is set on the clock edge after any MSI vector bit is 1. Clearing bit 28 while vector bits remain has no lasting effect. Once all vector bits are cleared, clearing bit 28 leaves it at zero.
- R7: Writing to the local status word or to the MSI vector register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R8: When an event sets a bit in the same cycle that software clears it, the bit ends up set. This holds for both status registers.
- R9: `irq_o` is the OR, over all bits, of local status AND mask. A mask bit of 1 enables its source. Writing 0 to the mask disables every source from the next cycle.
- R10: The register word index selects the register: 0 is the mask (read/write), 1 is the local status word (write-one-to-clear), 2 is the MSI vectors (write-one-to-clear), and 3 is the MSI target (read/write). In the mask and the local status word, only bits 16-18, 20-22 and 24-28 exist. Every other bit reads 0.
- R11: `irq_o` stays high after an unmasked event pulse ends, until software clears that status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_evt_i | input | 6 | Error event strobes: AXI post/fetch/discard, then PCIe post/fetch/discard |
| intx_evt_i | input | 4 | Legacy INTA..INTD assertions |
| msi_wr_i | input | 1 | Inbound MSI memory write valid |
| msi_addr_i | input | MSI_AW (32) | Address of the inbound MSI write |
| msi_data_i | input | MSI_DW (32) | Data of the inbound MSI write (vector number) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_idx_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_rd_i |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
A wrong bit position in the local status word shows up on the first read after a single-source pulse. If the summary flag is wired to the wrong vector state, the fault shows two cycles after an MSI write: the flag fails to appear, or it survives its own clear while vectors are still pending. A faulty clear or set-priority path leaves a neighbouring bit cleared, or a simultaneously set bit lost, in the next read. A mask or OR-reduction fault is visible on `irq_o` in the cycle right after the mask write.

// File: rtl/birq_pkg.sv
package birq_pkg;

  localparam int LW          = 32;
  localparam int ERR_N       = 6;
  localparam int INTX_N      = 4;
  localparam int INTX_BASE   = 24;
  localparam int MSI_SUM_BIT = 28;

  typedef enum logic [1:0] {
    RSEL_MASK  = 2'd0,
    RSEL_LSTAT = 2'd1,
    RSEL_MSTAT = 2'd2,
    RSEL_MTGT  = 2'd3
  } rsel_e;

  // Error source k lands at 16..18 (AXI side) and 20..22 (PCIe side).
  function automatic int err_bit(input int k);
    return (k < 3) ? (16 + k) : (17 + k);
  endfunction

  // Bits of the local word that actually exist.
  function automatic logic [LW-1:0] impl_bits();
    logic [LW-1:0] m;
    m = '0;
    for (int k = 0; k < ERR_N; k++)  m[err_bit(k)] = 1'b1;
    for (int j = 0; j < INTX_N; j++) m[INTX_BASE + j] = 1'b1;
    m[MSI_SUM_BIT] = 1'b1;
    return m;
  endfunction

  // Pack raw event inputs into their local-word positions.
  function automatic logic [LW-1:0] local_events(
    input logic [ERR_N-1:0]  err,
    input logic [INTX_N-1:0] intx,
    input logic              msi_any
  );
    logic [LW-1:0] v;
    v = '0;
    for (int k = 0; k < ERR_N; k++)  v[err_bit(k)] = err[k];
    for (int j = 0; j < INTX_N; j++) v[INTX_BASE + j] = intx[j];
    v[MSI_SUM_BIT] = msi_any;
    return v;
  endfunction

endpackage

// File: rtl/birq_w1c_bank.sv
module birq_w1c_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r;

  // One sticky flop per bit; a set in the same cycle beats a clear.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r[i] <= 1'b0;
      else        q_r[i] <= set_i[i] | (q_r[i] & ~clr_i[i]);
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/birq_msi_decode.sv
module birq_msi_decode #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int VECS = 32
) (
  input  logic                    valid_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           data_i,
  input  logic [AW-1:0]           target_i,
  output logic                    hit_o,
  output logic [$clog2(VECS)-1:0] idx_o,
  output logic [VECS-1:0]         set_o
);

  localparam int IW = $clog2(VECS);

  logic addr_ok;
  logic data_ok;

  assign addr_ok = (addr_i == target_i);
  assign data_ok = (data_i < DW'(VECS));
  assign hit_o   = valid_i && addr_ok && data_ok;
  assign idx_o   = data_i[IW-1:0];
  assign set_o   = hit_o ? (VECS'(1) << idx_o) : '0;

endmodule

// File: rtl/birq_regs.sv
module birq_regs
  import birq_pkg::*;
#(
  parameter int            AW      = 32,
  parameter int            VECS    = 32,
  parameter logic [AW-1:0] TGT_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [1:0]      idx_i,
  input  logic [LW-1:0]   wdata_i,
  input  logic [LW-1:0]   local_q_i,
  input  logic [VECS-1:0] msi_q_i,
  output logic [LW-1:0]   mask_o,
  output logic [AW-1:0]   target_o,
  output logic [LW-1:0]   local_clr_o,
  output logic [VECS-1:0] msi_clr_o,
  output logic [LW-1:0]   rdata_o,
  output logic            rvalid_o
);

  localparam logic [LW-1:0] IMPL = impl_bits();

  rsel_e         sel;
  logic [LW-1:0] mask_r;
  logic [AW-1:0] tgt_r;
  logic [LW-1:0] rdata_d;
  logic [LW-1:0] rdata_r;
  logic          rvalid_r;

  assign sel = rsel_e'(idx_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r <= '0;
      tgt_r  <= TGT_RST;
    end else if (wr_i) begin
      if (sel == RSEL_MASK) mask_r <= wdata_i & IMPL;
      if (sel == RSEL_MTGT) tgt_r  <= wdata_i[AW-1:0];
    end
  end

  assign local_clr_o = (wr_i && sel == RSEL_LSTAT) ? (wdata_i & IMPL) : '0;
  assign msi_clr_o   = (wr_i && sel == RSEL_MSTAT) ? wdata_i[VECS-1:0] : '0;

  always_comb begin
    rdata_d = '0;
    case (sel)
      RSEL_MASK:  rdata_d = mask_r;
      RSEL_LSTAT: rdata_d = local_q_i;
      RSEL_MSTAT: rdata_d = LW'(msi_q_i);
      RSEL_MTGT:  rdata_d = LW'(tgt_r);
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_r  <= '0;
      rvalid_r <= 1'b0;
    end else begin
      rvalid_r <= rd_i;
      if (rd_i) rdata_r <= rdata_d;
    end
  end

  assign mask_o   = mask_r;
  assign target_o = tgt_r;
  assign rdata_o  = rdata_r;
  assign rvalid_o = rvalid_r;

endmodule

// File: rtl/bridge_irq_agg.sv
module bridge_irq_agg
  import birq_pkg::*;
#(
  parameter int                MSI_AW      = 32,
  parameter int                MSI_DW      = 32,
  parameter int                MSI_VECS    = 32,
  parameter logic [MSI_AW-1:0] MSI_TGT_RST = MSI_AW'(32'h2000_0040)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        err_evt_i,
  input  logic [3:0]        intx_evt_i,
  input  logic              msi_wr_i,
  input  logic [MSI_AW-1:0] msi_addr_i,
  input  logic [MSI_DW-1:0] msi_data_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_idx_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              irq_o
);

  localparam int MSI_IW = $clog2(MSI_VECS);

  // Named internal events, observed by the bound checker.
  logic [LW-1:0]       local_q;
  logic [LW-1:0]       local_set;
  logic [LW-1:0]       local_clr;
  logic [MSI_VECS-1:0] msi_q;
  logic [MSI_VECS-1:0] msi_set;
  logic [MSI_VECS-1:0] msi_clr;
  logic                msi_hit;
  logic [MSI_IW-1:0]   msi_idx;
  logic                msi_any;
  logic [LW-1:0]       mask_q;
  logic [MSI_AW-1:0]   tgt_q;

  birq_msi_decode #(
    .AW   (MSI_AW),
    .DW   (MSI_DW),
    .VECS (MSI_VECS)
  ) u_dec (
    .valid_i  (msi_wr_i),
    .addr_i   (msi_addr_i),
    .data_i   (msi_data_i),
    .target_i (tgt_q),
    .hit_o    (msi_hit),
    .idx_o    (msi_idx),
    .set_o    (msi_set)
  );

  birq_w1c_bank #(.W(MSI_VECS)) u_msi_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (msi_set),
    .clr_i (msi_clr),
    .q_o   (msi_q)
  );

  // Summary follows registered vector state, so it re-asserts after a clear.
  assign msi_any   = |msi_q;
  assign local_set = local_events(err_evt_i, intx_evt_i, msi_any);

  birq_w1c_bank #(.W(LW)) u_local_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (local_set),
    .clr_i (local_clr),
    .q_o   (local_q)
  );

  birq_regs #(
    .AW      (MSI_AW),
    .VECS    (MSI_VECS),
    .TGT_RST (MSI_TGT_RST)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .idx_i       (reg_idx_i),
    .wdata_i     (reg_wdata_i),
    .local_q_i   (local_q),
    .msi_q_i     (msi_q),
    .mask_o      (mask_q),
    .target_o    (tgt_q),
    .local_clr_o (local_clr),
    .msi_clr_o   (msi_clr),
    .rdata_o     (reg_rdata_o),
    .rvalid_o    (reg_rvalid_o)
  );

  assign irq_o = |(local_q & mask_q);

endmodule

// File: rtl/birq_chk.sv
module birq_chk #(
  parameter int VECS = 32,
  parameter int IW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [5:0]      err_evt_i,
  input logic [3:0]      intx_evt_i,
  input logic            reg_wr_i,
  input logic [1:0]      reg_idx_i,
  input logic [31:0]     reg_wdata_i,
  input logic            irq_o,
  input logic [31:0]     local_q,
  input logic [VECS-1:0] msi_q,
  input logic [VECS-1:0] msi_clr,
  input logic            msi_hit,
  input logic [IW-1:0]   msi_idx
);

  logic [IW-1:0] idx_d;
  always_ff @(posedge clk) idx_d <= msi_idx;

  // R4
  msi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_hit |=> msi_q[idx_d]);

  // R5
  msi_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_hit && msi_clr == '0) |=> $stable(msi_q));

  // R6
  msi_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|msi_q) |=> local_q[28]);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_i[0] |=> local_q[16]);

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_idx_i == 2'd1 && reg_wdata_i[24] && !intx_evt_i[0])
      |=> !local_q[24]);

  // R9
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_idx_i == 2'd0 && reg_wdata_i == 32'd0) |=> !irq_o);

endmodule

bind bridge_irq_agg birq_chk #(.VECS(MSI_VECS), .IW(MSI_IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_evt_i   (err_evt_i),
  .intx_evt_i  (intx_evt_i),
  .reg_wr_i    (reg_wr_i),
  .reg_idx_i   (reg_idx_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .local_q     (local_q),
  .msi_q       (msi_q),
  .msi_clr     (msi_clr),
  .msi_hit     (msi_hit),
  .msi_idx     (msi_idx)
);

// File: tb/bridge_irq_agg_tb.sv
module bridge_irq_agg_tb;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] TGT0 = 32'h2000_0040;
  localparam logic [31:0] TGT1 = 32'h3000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  err_evt = '0;
  logic [3:0]  intx_evt = '0;
  logic        msi_wr = 1'b0;
  logic [31:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_irq_agg u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_evt_i    (err_evt),
    .intx_evt_i   (intx_evt),
    .msi_wr_i     (msi_wr),
    .msi_addr_i   (msi_addr),
    .msi_data_i   (msi_data),
    .reg_wr_i     (reg_wr),
    .reg_rd_i     (reg_rd),
    .reg_idx_i    (reg_idx),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .reg_rvalid_o (reg_rvalid),
    .irq_o        (irq)
  );

  // Monitor: pops expected read data as the design returns it.
  always @(negedge clk) begin
    if (reg_rvalid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: actual %h expected none", reg_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, input logic [31:0] e, input string t);
    reg_rd = 1'b1; reg_idx = idx;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic msi(input logic [31:0] a, input logic [31:0] d);
    msi_wr = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk);
    msi_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1, R10: reset values of every register
    chk_irq(1'b0, "R1 irq after reset");
    rd(2'd0, 32'h0, "R1 mask reset");
    rd(2'd1, 32'h0, "R1 local status reset");
    rd(2'd2, 32'h0, "R1 msi vectors reset");
    rd(2'd3, TGT0, "R1 msi target reset");

    // R2: all six error sources, sticky after the pulse
    err_evt = 6'b111111; @(negedge clk); err_evt = '0;
    idle(1);
    rd(2'd1, 32'h0077_0000, "R2 error bit positions");
    chk_irq(1'b0, "R9 masked sources keep irq low");

    // R3: INTB and INTD
    intx_evt = 4'b1010; @(negedge clk); intx_evt = '0;
    rd(2'd1, 32'h0A77_0000, "R3 intx bit positions");

    // R9, R7: enable one source, then clear exactly that bit
    wr(2'd0, 32'h0001_0000);
    chk_irq(1'b1, "R9 unmasked source drives irq");
    wr(2'd1, 32'h0001_0000);
    chk_irq(1'b0, "R7 irq drops after clear");
    rd(2'd1, 32'h0A76_0000, "R7 only written bit cleared");
    wr(2'd1, 32'h0);
    rd(2'd1, 32'h0A76_0000, "R7 zero write has no effect");

    // R10, R9: mask keeps only real bits; zero mask disables everything
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h1F77_0000, "R10 mask reserved bits read zero");
    chk_irq(1'b1, "R9 full mask");
    wr(2'd0, 32'h0);
    chk_irq(1'b0, "R9 zero mask disables all");

    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h0, "R7 clear all local bits");

    // R4, R6: accepted MSI writes
    msi(TGT0, 32'd5);
    idle(2);
    rd(2'd2, 32'h0000_0020, "R4 vector 5 set");
    rd(2'd1, 32'h1000_0000, "R6 summary bit set");
    msi(TGT0, 32'd31);
    idle(1);
    rd(2'd2, 32'h8000_0020, "R4 vector 31 set");

    // R5: out-of-range data and wrong address
    msi(TGT0, 32'd32);
    msi(TGT0 + 32'd4, 32'd3);
    idle(1);
    rd(2'd2, 32'h8000_0020, "R5 bad data or address ignored");

    // R5: reprogrammed target
    wr(2'd3, TGT1);
    rd(2'd3, TGT1, "R10 target readback");
    msi(TGT0, 32'd1);
    msi(TGT1, 32'd0);
    idle(1);
    rd(2'd2, 32'h8000_0021, "R5 only new target accepted");

    // R6: summary comes back while vectors remain, stays clear after
    wr(2'd1, 32'h1000_0000);
    idle(2);
    rd(2'd1, 32'h1000_0000, "R6 summary re-set while vectors pending");
    wr(2'd2, 32'h8000_0001);
    rd(2'd2, 32'h0000_0020, "R7 msi vectors cleared selectively");
    wr(2'd2, 32'hFFFF_FFFF);
    idle(1);
    wr(2'd1, 32'h1000_0000);
    idle(2);
    rd(2'd1, 32'h0, "R6 summary stays clear");

    // R8: set beats clear in the same cycle, both registers
    err_evt = 6'b000001;
    reg_wr = 1'b1; reg_idx = 2'd1; reg_wdata = 32'h0001_0000;
    @(negedge clk);
    err_evt = '0; reg_wr = 1'b0;
    rd(2'd1, 32'h0001_0000, "R8 local set wins");
    msi_wr = 1'b1; msi_addr = TGT1; msi_data = 32'd7;
    reg_wr = 1'b1; reg_idx = 2'd2; reg_wdata = 32'h0000_0080;
    @(negedge clk);
    msi_wr = 1'b0; reg_wr = 1'b0;
    rd(2'd2, 32'h0000_0080, "R8 msi set wins");
    wr(2'd2, 32'hFFFF_FFFF);
    idle(1);
    wr(2'd1, 32'hFFFF_FFFF);
    idle(2);
    rd(2'd1, 32'h0, "R7 cleanup");

    // R11: level output holds until cleared
    wr(2'd0, 32'h0100_0000);
    intx_evt = 4'b0001; @(negedge clk); intx_evt = '0;
    idle(5);
    chk_irq(1'b1, "R11 irq held after pulse");
    wr(2'd1, 32'h0100_0000);
    chk_irq(1'b0, "R11 irq released by clear");

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL reads missing: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule